// File: doc/BRIEF.md
# Berger Code Two-Rail Checker

This block validates separable Berger codewords. A codeword carries an information field of `INFO_W` bits followed by a check field of `CHK_W` bits. The check field holds the binary count of zero bits in the information field. On the receive side the block counts the zeros in the received information and inverts that count. It then compares the result bit by bit against the received check field, using a balanced tree of two-rail comparator cells.

Validity is reported as a pair of rails, `pair_f` and `pair_g`, rather than a single flag. The rails differ when the word is a valid codeword and are equal when it is not. A stuck or broken comparator therefore shows up as a non-complementary pair instead of a silent pass. A parameter selects whether the pair leaves through an output register or straight from the tree.

For the sending side, a separate generator forms the check field for an information word, so both ends of a link can be built from the same block.

Top module: `berger_checker`

## Requirements
- R1: The check field width is the smallest k with 2^k >= INFO_W+1; with the default INFO_W=8 it is 4 bits.
- R2: `tx_chk` equals the number of zero bits in `tx_info`, as an unsigned binary value; for example 8'b10101000 gives 4'b0101.
- R3: When `rx_chk` equals the zero count of `rx_info`, the outputs are complementary (`pair_f` != `pair_g`).
- R4: Any single flipped bit in the 12-bit codeword (information or check field) makes `pair_f` equal to `pair_g`.
- R5: Any unidirectional error (some 0 bits set to 1, or some 1 bits cleared to 0, across the whole codeword) makes `pair_f` equal to `pair_g`.
- R6: With REG_OUT=1 the pair reflects the inputs sampled at the previous rising clock edge; with REG_OUT=0 it follows the inputs in the same cycle.
- R7: With REG_OUT=1, while `rst_n` is low the outputs read `pair_f`=0 and `pair_g`=1 (the valid code).
- R8: The extreme words are accepted: all-ones information with check 4'b0000, and all-zeros information with check 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| rx_info | input | INFO_W | Received information field |
| rx_chk | input | CHK_W | Received check field |
| tx_info | input | INFO_W | Information word for the check-bit generator |
| tx_chk | output | CHK_W | Generated check field (zero count of tx_info) |
| pair_f | output | 1 | First validity rail |
| pair_g | output | 1 | Second validity rail, the complement of pair_f for a valid word |

## Verification
A wrong zero count or a miswired comparator cell shows up at the ports as a valid codeword that yields equal rails, or as a corrupted word that yields complementary rails. In the combinational variant this appears in the same cycle. In the registered variant it appears one edge after the word is applied. The bench applies all 256 valid codewords, every single-bit corruption of each, and pseudo-random unidirectional corruptions in both directions. Any faulty count bit or tree cell is therefore exposed within the first sweep. A register that holds stale data is caught by the one-cycle latency check.

// File: rtl/berger_pkg.sv
package berger_pkg;

    // Value presented on the two rails.
    typedef struct packed {
        logic f;
        logic g;
    } rail_pair_t;

    // Reset value of the output register: a complementary (valid) pair.
    localparam rail_pair_t RAIL_RESET = '{f: 1'b0, g: 1'b1};

    // Width needed to hold a count of 0..n.
    function automatic int count_width(input int n);
        int w;
        w = 0;
        while ((1 << w) < (n + 1)) begin
            w++;
        end
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/berger_zero_count.sv
module berger_zero_count #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  zeros
);

    logic [CNT_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            acc = acc + CNT_W'(!data[i]);
        end
    end

    assign zeros = acc;

endmodule

// File: rtl/berger_trc_cell.sv
module berger_trc_cell (
    input  logic a1,
    input  logic b1,
    input  logic a2,
    input  logic b2,
    output logic z1,
    output logic z2
);

    // Two-rail merge: complementary out only if both inputs are complementary.
    assign z1 = (a1 & a2) | (b1 & b2);
    assign z2 = (a1 & b2) | (b1 & a2);

endmodule

// File: rtl/berger_trc_tree.sv
module berger_trc_tree #(
    parameter int PAIRS = 4
) (
    input  logic [PAIRS-1:0] rail_a,
    input  logic [PAIRS-1:0] rail_b,
    output logic             z1,
    output logic             z2
);

    localparam int LEVELS = (PAIRS <= 1) ? 0 : $clog2(PAIRS);
    localparam int LEAVES = 1 << LEVELS;

    // Heap layout: node 1 is the root, node n has children 2n and 2n+1.
    logic [2*LEAVES-1:1] node_a;
    logic [2*LEAVES-1:1] node_b;

    generate
        for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
            if (j < PAIRS) begin : g_real
                assign node_a[LEAVES+j] = rail_a[j];
                assign node_b[LEAVES+j] = rail_b[j];
            end else begin : g_pad
                // Padding leaf: a fixed complementary pair.
                assign node_a[LEAVES+j] = 1'b0;
                assign node_b[LEAVES+j] = 1'b1;
            end
        end

        for (genvar n = 1; n < LEAVES; n++) begin : g_node
            berger_trc_cell u_cell (
                .a1 (node_a[2*n]),
                .b1 (node_b[2*n]),
                .a2 (node_a[2*n+1]),
                .b2 (node_b[2*n+1]),
                .z1 (node_a[n]),
                .z2 (node_b[n])
            );
        end
    endgenerate

    assign z1 = node_a[1];
    assign z2 = node_b[1];

endmodule

// File: rtl/berger_checker.sv
module berger_checker
    import berger_pkg::*;
#(
    parameter int INFO_W  = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int CHK_W  = count_width(INFO_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INFO_W-1:0] rx_info,
    input  logic [CHK_W-1:0]  rx_chk,
    input  logic [INFO_W-1:0] tx_info,
    output logic [CHK_W-1:0]  tx_chk,
    output logic              pair_f,
    output logic              pair_g
);

    logic [CHK_W-1:0] rx_zeros;
    logic [CHK_W-1:0] rx_zeros_n;
    logic             tree_z1;
    logic             tree_z2;
    rail_pair_t       pair_d;
    rail_pair_t       pair_q;

    // Encoder-side generator.
    berger_zero_count #(.DATA_W(INFO_W), .CNT_W(CHK_W)) u_tx_count (
        .data  (tx_info),
        .zeros (tx_chk)
    );

    // Receive-side count, inverted to form the complement rails.
    berger_zero_count #(.DATA_W(INFO_W), .CNT_W(CHK_W)) u_rx_count (
        .data  (rx_info),
        .zeros (rx_zeros)
    );

    assign rx_zeros_n = ~rx_zeros;

    berger_trc_tree #(.PAIRS(CHK_W)) u_tree (
        .rail_a (rx_zeros_n),
        .rail_b (rx_chk),
        .z1     (tree_z1),
        .z2     (tree_z2)
    );

    always_comb begin
        pair_d   = pair_q;
        pair_d.f = tree_z1;
        pair_d.g = tree_z2;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pair_q <= RAIL_RESET;
                end else begin
                    pair_q <= pair_d;
                end
            end
            assign pair_f = pair_q.f;
            assign pair_g = pair_q.g;

            // R6
            reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tree_z1 != tree_z2) |=> (pair_f != pair_g));
        end else begin : g_comb
            assign pair_q = RAIL_RESET;
            assign pair_f = pair_d.f;
            assign pair_g = pair_d.g;
        end
    endgenerate

    // R2
    zero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_zeros <= CHK_W'(INFO_W)) && (tx_chk <= CHK_W'(INFO_W)));

    // R3
    valid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_chk == rx_zeros) |-> (tree_z1 != tree_z2));

    // R4
    error_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_chk != rx_zeros) |-> (tree_z1 == tree_z2));

endmodule

// File: tb/berger_checker_bench.sv
`timescale 1ns/1ps
module berger_checker_bench;

    localparam int IW = 8;
    localparam int KW = 4;
    localparam int CW = IW + KW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] rx_info = '0;
    logic [KW-1:0] rx_chk = '0;
    logic [IW-1:0] tx_info = '0;
    logic [KW-1:0] tx_chk_r, tx_chk_c;
    logic          f_r, g_r, f_c, g_c;

    always #2.5 clk = ~clk;

    berger_checker #(.INFO_W(IW), .REG_OUT(1'b1)) u_berger_checker (
        .clk(clk), .rst_n(rst_n), .rx_info(rx_info), .rx_chk(rx_chk),
        .tx_info(tx_info), .tx_chk(tx_chk_r), .pair_f(f_r), .pair_g(g_r)
    );

    berger_checker #(.INFO_W(IW), .REG_OUT(1'b0)) u_berger_checker_comb (
        .clk(clk), .rst_n(rst_n), .rx_info(rx_info), .rx_chk(rx_chk),
        .tx_info(tx_info), .tx_chk(tx_chk_c), .pair_f(f_c), .pair_g(g_c)
    );

    typedef struct {
        bit    valid;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    function automatic logic [KW-1:0] zeros_of(input logic [IW-1:0] v);
        int c;
        c = 0;
        for (int i = 0; i < IW; i++) if (v[i] == 1'b0) c++;
        return KW'(c);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: applies a word at the falling edge and queues its expectation.
    task automatic drive(input logic [IW-1:0] info, input logic [KW-1:0] chk,
                         input bit valid, input string req);
        exp_t e;
        @(negedge clk);
        rx_info = info;
        rx_chk  = chk;
        e.valid = valid;
        e.req   = req;
        sb_q.push_back(e);
    endtask

    // Monitor: after each rising edge, compare both variants with the queue head.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check((f_r != g_r) == e.valid, e.req, "registered pair complementary",
                  int'(f_r != g_r), int'(e.valid));
            check((f_c != g_c) == e.valid, e.req, "combinational pair complementary",
                  int'(f_c != g_c), int'(e.valid));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [CW-1:0] lfsr;
        logic [CW-1:0] cw;
        logic [CW-1:0] bad;
        int            k;

        // R7: reset state of the registered variant
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(f_r == 1'b0 && g_r == 1'b1, "R7", "reset pair {f,g}",
              int'({f_r, g_r}), 1);

        // R1: check width from INFO_W
        k = 0;
        while ((1 << k) < IW + 1) k++;
        check(k == $bits(tx_chk_r), "R1", "check field width", $bits(tx_chk_r), k);
        check(u_berger_checker.CHK_W == k, "R1", "CHK_W", u_berger_checker.CHK_W, k);

        @(negedge clk);
        rst_n = 1'b1;

        // R2: generator over every information value, plus the worked example
        for (int v = 0; v < (1 << IW); v++) begin
            tx_info = IW'(v);
            #0.5;
            check(tx_chk_r == zeros_of(IW'(v)), "R2", "tx_chk registered variant",
                  int'(tx_chk_r), int'(zeros_of(IW'(v))));
            check(tx_chk_c == zeros_of(IW'(v)), "R2", "tx_chk combinational variant",
                  int'(tx_chk_c), int'(zeros_of(IW'(v))));
        end
        tx_info = 8'b1010_1000;
        #0.5;
        check(tx_chk_r == 4'b0101, "R2", "tx_chk for 10101000", int'(tx_chk_r), 5);

        // R8: extreme codewords
        drive(8'hFF, 4'b0000, 1'b1, "R8");
        drive(8'h00, 4'b1000, 1'b1, "R8");

        // R3: every valid codeword
        for (int v = 0; v < (1 << IW); v++) begin
            drive(IW'(v), zeros_of(IW'(v)), 1'b1, "R3");
        end

        // R4: every single-bit error of every codeword
        for (int v = 0; v < (1 << IW); v++) begin
            cw = {IW'(v), zeros_of(IW'(v))};
            for (int b = 0; b < CW; b++) begin
                bad = cw ^ (CW'(1) << b);
                drive(bad[CW-1:KW], bad[KW-1:0], 1'b0, "R4");
            end
        end

        // R5: unidirectional multi-bit errors, both directions
        lfsr = 12'hACE;
        for (int v = 0; v < (1 << IW); v++) begin
            cw = {IW'(v), zeros_of(IW'(v))};
            for (int r = 0; r < 3; r++) begin
                lfsr = {lfsr[CW-2:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
                bad = cw | lfsr;
                if (bad != cw) drive(bad[CW-1:KW], bad[KW-1:0], 1'b0, "R5");
                bad = cw & ~lfsr;
                if (bad != cw) drive(bad[CW-1:KW], bad[KW-1:0], 1'b0, "R5");
            end
            bad = '1;
            if (bad != cw) drive(bad[CW-1:KW], bad[KW-1:0], 1'b0, "R5");
            bad = '0;
            drive(bad[CW-1:KW], bad[KW-1:0], 1'b0, "R5");
        end

        // R6: registered output lags one edge, combinational does not
        drive(8'h0F, 4'b0100, 1'b1, "R6");
        @(negedge clk);
        rx_info = 8'h0F;
        rx_chk  = 4'b0011;
        begin
            exp_t e;
            e.valid = 1'b0;
            e.req   = "R6";
            sb_q.push_back(e);
        end
        #1;
        check(f_r != g_r, "R6", "registered pair before edge still valid",
              int'(f_r != g_r), 1);
        check(f_c == g_c, "R6", "combinational pair already invalid",
              int'(f_c == g_c), 1);

        repeat (3) @(posedge clk);
        #2;
        check(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule